// File: doc/BRIEF.md
# Reconfigurable-View Tile Buffer

This block is an on-chip memory unit built around two flat, linearly addressed banks. Commands arrive with their fields on parallel inputs and a valid/ready handshake. Each command can do two things at once. It can fill one bank from the input stream with a given number of words. It can also read a rectangular sub-tile out of the other bank and stream it to one of several output ports. A bank select bit in each command chooses which bank fills and which bank drains, so consecutive commands can alternate the two banks.

Storage has no fixed shape. When a bank is filled, the command also gives a matrix width, and the block latches that width for the bank. A later send from that bank treats the flat storage as a matrix with that row stride. A sub-tile is then any inclusive window of rows and columns. The same capacity can therefore hold a tall matrix or a wide one without padding. Inside each bank, words are interleaved across lanes by address.

Top module: `tile_view_buffer`

## Requirements
- R1: After reset, cmd_ready_o is 1, in_ready_o is 0 and every bit of out_valid_o is 0.
- R2: A command is taken when cmd_valid_i and cmd_ready_o are both 1. cmd_ready_o then stays 0 until both the receive and the send part of that command have finished. It then returns to 1, unless the command was marked last.
- R3: When cmd_rx_en_i is 1, the block accepts exactly min(cmd_count_i, DEPTH) input words. They are written to addresses 0, 1, 2, ... of the receiving bank. cmd_bank_i = 0 makes bank 0 receive and bank 1 send; cmd_bank_i = 1 reverses the roles. in_ready_o is 0 at all other times.
- R4: When cmd_tx_en_i is 1, the send part streams the words of rows cmd_row_lo_i..cmd_row_hi_i and columns cmd_col_lo_i..cmd_col_hi_i (both ends inclusive) from the sending bank. Words go out in row-major order, and each is read at address (row * stride + col) mod DEPTH.
- R5: A command with cmd_rx_en_i = 1 latches cmd_width_i as the stride of its receiving bank. A send uses the stride latched for the sending bank and ignores the send command's own cmd_width_i.
- R6: Sent words appear only on output port cmd_dst_i. At most one bit of out_valid_o is 1 at any time. Port p carries its data on out_data_o[p*DATA_W +: DATA_W].
- R7: A window with row_lo > row_hi or col_lo > col_hi, or a command with cmd_tx_en_i = 0, sends nothing. A count of 0, or cmd_rx_en_i = 0, receives nothing. Such a command still completes.
- R8: While the active port holds valid and its ready is 0, the word and the valid stay unchanged. No word is lost or repeated.
- R9: After a command with cmd_last_i = 1 completes, cmd_ready_o stays 0 until reset.
- R10: Data in a bank that is not receiving is preserved across commands. The bank keeps its contents until it receives again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Decoder idle and ready for a command |
| cmd_last_i | input | 1 | Stop the decoder after this command |
| cmd_bank_i | input | 1 | 0: bank 0 receives, bank 1 sends; 1: reversed |
| cmd_rx_en_i | input | 1 | Enable the receive part |
| cmd_tx_en_i | input | 1 | Enable the send part |
| cmd_dst_i | input | DST_W | Output port for sent words |
| cmd_count_i | input | CNT_W | Words to receive |
| cmd_width_i | input | CNT_W | Matrix width (row stride) of the received data |
| cmd_row_lo_i | input | ADDR_W | First window row |
| cmd_row_hi_i | input | ADDR_W | Last window row (inclusive) |
| cmd_col_lo_i | input | ADDR_W | First window column |
| cmd_col_hi_i | input | ADDR_W | Last window column (inclusive) |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DATA_W | Input word |
| in_ready_o | output | 1 | Input word accepted |
| out_valid_o | output | N_OUT | Per-port output valid |
| out_data_o | output | N_OUT*DATA_W | Per-port output data |
| out_ready_i | input | N_OUT | Per-port output ready |

## Verification
The bench builds the block with its defaults: DEPTH 64, four lanes, 16-bit words and four output ports, so CNT_W is 7 and ADDR_W is 6. A 7-bit count can exceed the 64-word capacity, which puts the clamp in R3 within reach. Full-bank loads and reads at every lane offset exercise the interleaved storage. Strides from 1 to 16 let one 64-word bank be read back as 64x1, 4x16, 16x4 and other shapes. Four ports with random per-port ready give backpressure and port selection on every send.

// File: rtl/tvb_pkg.sv
`timescale 1ns/1ps
package tvb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HALT = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/tvb_bank_store.sv
`timescale 1ns/1ps
module tvb_bank_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam int ROWS   = DEPTH / LANES;

  logic [DATA_W-1:0] lane_rd [LANES];

  // cyclic interleave: low address bits pick the lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] mem_q [ROWS];
    logic lane_we;
    assign lane_we = we_i && (waddr_i[LANE_W-1:0] == LANE_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
      end else if (lane_we) begin
        mem_q[waddr_i[ADDR_W-1:LANE_W]] <= wdata_i;
      end
    end

    assign lane_rd[l] = mem_q[raddr_i[ADDR_W-1:LANE_W]];
  end

  assign rdata_o = lane_rd[raddr_i[LANE_W-1:0]];
endmodule

// File: rtl/tvb_rx_unit.sv
`timescale 1ns/1ps
module tvb_rx_unit #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              busy_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q, lim_q, lim_d;

  assign lim_d = (count_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else if (start_i) begin
      active_q <= (lim_d != '0);
      cnt_q    <= '0;
      lim_q    <= lim_d;
    end else if (we_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == lim_q) active_q <= 1'b0;
    end
  end

  assign in_ready_o = active_q;
  assign we_o       = active_q && in_valid_i;
  assign waddr_o    = cnt_q[ADDR_W-1:0];
  assign busy_o     = active_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (cnt_q < lim_q));
endmodule

// File: rtl/tvb_tx_agu.sv
`timescale 1ns/1ps
module tvb_tx_agu #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] row_lo_i,
  input  logic [ADDR_W-1:0] row_hi_i,
  input  logic [ADDR_W-1:0] col_lo_i,
  input  logic [ADDR_W-1:0] col_hi_i,
  input  logic [CNT_W-1:0]  stride_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              busy_o
);
  localparam int PW = ADDR_W + CNT_W;

  logic              active_q, ov_q;
  logic [DATA_W-1:0] od_q;
  logic [ADDR_W-1:0] row_q, col_q, row_hi_q, col_lo_q, col_hi_q;
  logic [CNT_W-1:0]  stride_q;
  logic              advance;

  assign raddr_o = ADDR_W'(PW'(row_q) * PW'(stride_q) + PW'(col_q));
  assign advance = active_q && (!ov_q || out_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
      row_q    <= '0;
      col_q    <= '0;
      row_hi_q <= '0;
      col_lo_q <= '0;
      col_hi_q <= '0;
      stride_q <= '0;
    end else if (start_i) begin
      active_q <= (row_lo_i <= row_hi_i) && (col_lo_i <= col_hi_i);
      row_q    <= row_lo_i;
      col_q    <= col_lo_i;
      row_hi_q <= row_hi_i;
      col_lo_q <= col_lo_i;
      col_hi_q <= col_hi_i;
      stride_q <= stride_i;
    end else if (advance) begin
      ov_q <= 1'b1;
      od_q <= rdata_i;
      if (col_q == col_hi_q) begin
        col_q <= col_lo_q;
        row_q <= row_q + 1'b1;
        if (row_q == row_hi_q) active_q <= 1'b0;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else if (ov_q && out_ready_i) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign busy_o      = active_q || ov_q;

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && !out_ready_i) |=> (ov_q && $stable(od_q)));
endmodule

// File: rtl/tvb_cmd_ctrl.sv
`timescale 1ns/1ps
module tvb_cmd_ctrl #(
  parameter int DEPTH = 64,
  parameter int N_OUT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int DST_W = $clog2(N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_last_i,
  input  logic             cmd_bank_i,
  input  logic             cmd_rx_en_i,
  input  logic             cmd_tx_en_i,
  input  logic [DST_W-1:0] cmd_dst_i,
  input  logic [CNT_W-1:0] cmd_width_i,
  input  logic             rx_busy_i,
  input  logic             tx_busy_i,
  output logic             rx_start_o,
  output logic             tx_start_o,
  output logic [CNT_W-1:0] tx_stride_o,
  output logic             rx_bank_o,
  output logic [DST_W-1:0] dst_o
);
  import tvb_pkg::*;

  ctrl_state_e      state_q;
  logic             accept, last_q, bank_q;
  logic [DST_W-1:0] dst_q;
  logic [CNT_W-1:0] stride_q [2];

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign rx_start_o  = accept && cmd_rx_en_i;
  assign tx_start_o  = accept && cmd_tx_en_i;
  assign tx_stride_o = stride_q[!cmd_bank_i];
  assign rx_bank_o   = bank_q;
  assign dst_o       = dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      last_q      <= 1'b0;
      bank_q      <= 1'b0;
      dst_q       <= '0;
      stride_q[0] <= '0;
      stride_q[1] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_BUSY;
          last_q  <= cmd_last_i;
          bank_q  <= cmd_bank_i;
          dst_q   <= cmd_dst_i;
          if (cmd_rx_en_i) stride_q[cmd_bank_i] <= cmd_width_i;
        end
        ST_BUSY: if (!rx_busy_i && !tx_busy_i) begin
          state_q <= last_q ? ST_HALT : ST_IDLE;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!rx_busy_i && !tx_busy_i));
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> (state_q == ST_HALT) && !cmd_ready_o);
endmodule

// File: rtl/tile_view_buffer.sv
`timescale 1ns/1ps
module tile_view_buffer #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int N_OUT  = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int DST_W  = $clog2(N_OUT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic                    cmd_last_i,
  input  logic                    cmd_bank_i,
  input  logic                    cmd_rx_en_i,
  input  logic                    cmd_tx_en_i,
  input  logic [DST_W-1:0]        cmd_dst_i,
  input  logic [CNT_W-1:0]        cmd_count_i,
  input  logic [CNT_W-1:0]        cmd_width_i,
  input  logic [ADDR_W-1:0]       cmd_row_lo_i,
  input  logic [ADDR_W-1:0]       cmd_row_hi_i,
  input  logic [ADDR_W-1:0]       cmd_col_lo_i,
  input  logic [ADDR_W-1:0]       cmd_col_hi_i,
  input  logic                    in_valid_i,
  input  logic [DATA_W-1:0]       in_data_i,
  output logic                    in_ready_o,
  output logic [N_OUT-1:0]        out_valid_o,
  output logic [N_OUT*DATA_W-1:0] out_data_o,
  input  logic [N_OUT-1:0]        out_ready_i
);
  logic              rx_start, tx_start, rx_busy, tx_busy, rx_we, rx_bank;
  logic [CNT_W-1:0]  tx_stride;
  logic [DST_W-1:0]  dst;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata, tx_data;
  logic              tx_valid, tx_ready;
  logic [DATA_W-1:0] bank_rd [2];

  tvb_cmd_ctrl #(.DEPTH(DEPTH), .N_OUT(N_OUT)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_last_i, .cmd_bank_i,
    .cmd_rx_en_i, .cmd_tx_en_i, .cmd_dst_i, .cmd_width_i,
    .rx_busy_i(rx_busy), .tx_busy_i(tx_busy),
    .rx_start_o(rx_start), .tx_start_o(tx_start), .tx_stride_o(tx_stride),
    .rx_bank_o(rx_bank), .dst_o(dst)
  );

  tvb_rx_unit #(.DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni, .start_i(rx_start), .count_i(cmd_count_i),
    .in_valid_i, .in_ready_o, .we_o(rx_we), .waddr_o(waddr), .busy_o(rx_busy)
  );

  tvb_tx_agu #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start),
    .row_lo_i(cmd_row_lo_i), .row_hi_i(cmd_row_hi_i),
    .col_lo_i(cmd_col_lo_i), .col_hi_i(cmd_col_hi_i),
    .stride_i(tx_stride), .raddr_o(raddr), .rdata_i(rdata),
    .out_valid_o(tx_valid), .out_data_o(tx_data), .out_ready_i(tx_ready),
    .busy_o(tx_busy)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tvb_bank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(LANES)) u_store (
      .clk_i, .rst_ni,
      .we_i(rx_we && (rx_bank == 1'(b))), .waddr_i(waddr), .wdata_i(in_data_i),
      .raddr_i(raddr), .rdata_o(bank_rd[b])
    );
  end

  assign rdata    = bank_rd[!rx_bank];
  assign tx_ready = out_ready_i[dst];

  for (genvar p = 0; p < N_OUT; p++) begin : g_port
    logic sel;
    assign sel = (dst == DST_W'(p));
    assign out_valid_o[p]                 = tx_valid && sel;
    assign out_data_o[p*DATA_W +: DATA_W] = sel ? tx_data : '0;
  end

  a_r3_rx_inside_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !cmd_ready_o);
  a_r6_single_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));
  a_r6_port_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|out_valid_o) && !(|(out_valid_o & out_ready_i))) |=> $stable(out_valid_o));
endmodule

// File: tb/tile_view_buffer_tb_top.sv
`timescale 1ns/1ps
module tile_view_buffer_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 64;
  localparam int N_OUT  = 4;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 7;
  localparam int DST_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                    cmd_valid = 0, cmd_ready, cmd_last = 0, cmd_bank = 0;
  logic                    cmd_rx_en = 0, cmd_tx_en = 0;
  logic [DST_W-1:0]        cmd_dst = 0;
  logic [CNT_W-1:0]        cmd_count = 0, cmd_width = 0;
  logic [ADDR_W-1:0]       row_lo = 0, row_hi = 0, col_lo = 0, col_hi = 0;
  logic                    in_valid = 0, in_ready;
  logic [DATA_W-1:0]       in_data = 0;
  logic [N_OUT-1:0]        out_valid, out_ready = 0;
  logic [N_OUT*DATA_W-1:0] out_data;

  tile_view_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANES(4), .N_OUT(N_OUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_last_i(cmd_last),
    .cmd_bank_i(cmd_bank), .cmd_rx_en_i(cmd_rx_en), .cmd_tx_en_i(cmd_tx_en),
    .cmd_dst_i(cmd_dst), .cmd_count_i(cmd_count), .cmd_width_i(cmd_width),
    .cmd_row_lo_i(row_lo), .cmd_row_hi_i(row_hi),
    .cmd_col_lo_i(col_lo), .cmd_col_hi_i(col_hi),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int n_cmp = 0, n_bad = 0;
  int ref_mem [2][DEPTH];
  int ref_stride [2];
  bit done_all = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rx_len(bit en, int cnt);
    if (!en) return 0;
    return (cnt > DEPTH) ? DEPTH : cnt;
  endfunction

  task automatic run_cmd(bit last, bit bank, bit rx, bit tx, int dst, int cnt, int width,
                         int rlo, int rhi, int clo, int chi);
    int exp_q[$];
    int words [DEPTH];
    int n_rx, sent, got, cyc, tail, s;
    bit accepted, stall, finish;
    logic [N_OUT-1:0] pv;
    logic [DATA_W-1:0] pd;
    s = ref_stride[!bank];
    if (tx && rlo <= rhi && clo <= chi)
      for (int r = rlo; r <= rhi; r++)
        for (int c = clo; c <= chi; c++)
          exp_q.push_back(ref_mem[!bank][(r * s + c) % DEPTH]);
    n_rx = rx_len(rx, cnt);
    for (int i = 0; i < DEPTH; i++) words[i] = $urandom % 65536;
    sent = 0; got = 0; cyc = 0; tail = 0; accepted = 0; stall = 0; finish = 0;
    pv = '0; pd = '0;
    while (!finish) begin
      @(negedge clk);
      cmd_valid = !accepted;
      cmd_last = last; cmd_bank = bank; cmd_rx_en = rx; cmd_tx_en = tx;
      cmd_dst = DST_W'(dst); cmd_count = CNT_W'(cnt); cmd_width = CNT_W'(width);
      row_lo = ADDR_W'(rlo); row_hi = ADDR_W'(rhi); col_lo = ADDR_W'(clo); col_hi = ADDR_W'(chi);
      in_valid = ($urandom % 4) != 0;
      in_data = (sent < n_rx) ? DATA_W'(words[sent]) : DATA_W'($urandom);
      out_ready = N_OUT'($urandom) | ((($urandom % 3) != 0) ? N_OUT'(1 << dst) : '0);
      #1;
      if (stall) check(out_valid == pv && out_data[dst*DATA_W +: DATA_W] == pd,
                       "R8 stalled word held", int'(out_data[dst*DATA_W +: DATA_W]), int'(pd));
      if (out_valid != 0) begin
        check(out_valid == N_OUT'(1 << dst), "R6 port select", int'(out_valid), 1 << dst);
        if (got < exp_q.size())
          check(out_data[dst*DATA_W +: DATA_W] == DATA_W'(exp_q[got]), "R4 window word",
                int'(out_data[dst*DATA_W +: DATA_W]), exp_q[got]);
        else
          check(0, "R7 word beyond window", got, exp_q.size());
        if (out_ready[dst]) got++;
      end
      stall = (out_valid != 0) && !(|(out_valid & out_ready));
      pv = out_valid; pd = out_data[dst*DATA_W +: DATA_W];
      if (in_ready) begin
        if (sent >= n_rx) check(0, "R3 input taken past count", sent + 1, n_rx);
        else if (in_valid) sent++;
      end
      if (accepted && sent == n_rx && got == exp_q.size()) tail++;
      if (!accepted && cmd_ready) accepted = 1;
      if (last) begin
        if (tail > 2) check(!cmd_ready, "R9 halted after last", int'(cmd_ready), 0);
        if (tail > 10) finish = 1;
      end else if (tail > 1 && cmd_ready) finish = 1;
      cyc++;
      if (cyc > 3000) begin
        check(0, "R2 command did not complete", cyc, 0);
        finish = 1;
      end
    end
    check(sent == n_rx, "R3 words received", sent, n_rx);
    check(got == exp_q.size(), "R4 words sent", got, exp_q.size());
    for (int i = 0; i < n_rx; i++) ref_mem[bank][i] = words[i];
    if (rx) ref_stride[bank] = width;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 2; b++) begin
      ref_stride[b] = 0;
      for (int i = 0; i < DEPTH; i++) ref_mem[b][i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(cmd_ready == 1'b1, "R1 cmd_ready after reset", int'(cmd_ready), 1);
    check(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    check(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R3 R5: full load of bank 0 as 8 wide
    run_cmd(0, 0, 1, 0, 0, 64, 8, 0, 0, 0, 0);
    // R4: send bank 0 with stride 8 while loading bank 1 as 16 wide
    run_cmd(0, 1, 1, 1, 2, 64, 16, 1, 3, 2, 5);
    // R5: send from bank 1 uses 16, not this command's width 4
    run_cmd(0, 0, 1, 1, 3, 32, 4, 0, 1, 10, 15);
    // R10: bank 0 reshaped as 4 wide, upper half still from first load
    run_cmd(0, 1, 0, 1, 0, 0, 9, 2, 15, 0, 3);
    // R7: empty windows and zero count
    run_cmd(0, 1, 1, 1, 1, 0, 8, 3, 1, 0, 2);
    run_cmd(0, 0, 0, 1, 1, 5, 8, 0, 2, 3, 1);
    // R3: count above capacity clamps, full-bank send
    run_cmd(0, 1, 1, 1, 1, 100, 8, 0, 15, 0, 3);
    for (int k = 0; k < 40; k++) begin
      int bank, w, s, rows, rlo, rhi, clo, chi;
      bank = $urandom % 2;
      w = 1 + $urandom % 16;
      s = ref_stride[!bank];
      if (s == 0) s = 1;
      rows = DEPTH / s;
      if (rows > 16) rows = 16;
      rlo = $urandom % rows; rhi = $urandom % rows;
      clo = $urandom % s; chi = $urandom % s;
      if (rlo > rhi && ($urandom % 4) != 0) begin int t = rlo; rlo = rhi; rhi = t; end
      if (clo > chi && ($urandom % 4) != 0) begin int t = clo; clo = chi; chi = t; end
      run_cmd(0, bank[0], ($urandom % 5) != 0, ($urandom % 5) != 0, $urandom % N_OUT,
              $urandom % 72, w, rlo, rhi, clo, chi);
    end
    // R9: last command then halt
    run_cmd(1, 0, 1, 1, 2, 6, 3, 0, 1, 0, 1);
    repeat (4) begin
      @(negedge clk); cmd_valid = 1; #1;
      check(!cmd_ready && !in_ready, "R9 no further commands", int'(cmd_ready), 0);
    end
    done_all = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done_all) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule